// File: doc/BRIEF.md
# LCD Driver Serial Command and Display-Data Receiver

This block is the serial front end of a cascadable LCD segment driver. It watches a two-wire I2C bus through a system clock that oversamples SCL and SDA. It finds START and STOP conditions and accepts a write transfer aimed at a 7-bit slave address. The upper six address bits are fixed at `011100`, and the lowest bit must equal the level on a strap pin. Two groups of drivers can therefore share one bus, and each group can hold up to eight devices that are told apart by a 3-bit hardware subaddress.

After the address byte comes a chain of command bytes. Bit 7 of each command byte is a continuation flag. The first command byte with that flag cleared closes the command phase, and every byte after it is display data. Command bytes load the mode, bank and blink registers, the display-data pointer and the subaddress counter.

Every device on the bus tracks the data pointer and the subaddress counter in step. A display byte is acknowledged and written into the display RAM only by the device whose strap subaddress equals the counter. When the pointer runs past the end of the RAM, the counter moves on to the next device in the cascade.

Top module: `lcdI2cRx`

## Requirements
- R1: After reset, `sdaOe` is low, the mode, bank and blink outputs are zero, the data pointer is 0 and the subaddress counter is 0.
- R2: A first byte after START equal to `011100` followed by `sa0Strap` and then a 0 (write) is acknowledged. Any other first byte gets no acknowledge, and every byte that follows it up to the next START is ignored: no acknowledge, no register change and no RAM write.
- R3: Once the address is accepted, command bytes are acknowledged whatever the subaddress is. A command byte with bit 7 = 1 is followed by another command byte. The first command byte with bit 7 = 0 is the last one, and every later byte of the transfer is display data.
- R4: A command byte with bits 6:5 = `10` sets `dispEn` from bit 3, `biasSel` from bit 2 and `dutySel` from bits 1:0. Outside command bytes, the mode, bank and blink outputs hold their values.
- R5: A command byte with bit 6 = 0 loads the data pointer from bits 5:0. A value above 39 loads 0 instead.
- R6: Command bytes with bits 6:3 set as follows: `1100` loads the subaddress counter from bits 2:0, `1110` loads `bankSel` from bits 1:0, `1111` loads `blinkSel` from bits 1:0, and `1101` is reserved and changes nothing.
- R7: A display byte is acknowledged, and gives a one-cycle `ramWe` pulse with `ramAddr` equal to the data pointer and `ramData` equal to the byte, only when `subAddr` equals the subaddress counter.
- R8: After each display byte, on every device, the pointer advances by 8, 4, 3 or 2 for `dutySel` 0, 1, 2 or 3.
- R9: When the advanced pointer would reach 40 or more, it becomes 0 and the subaddress counter increments modulo 8.
- R10: `sdaOe` rises while SCL is low after the eighth bit of an acknowledged byte, is high through the ninth SCL high phase, and falls after the ninth SCL falling edge.
- R11: A START in the middle of a byte restarts parsing, and the next byte is taken as an address. After STOP, bytes sent without a new START are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sa0Strap | input | 1 | Strap that sets the address LSB |
| subAddr | input | 3 | Hardware subaddress of this device in the cascade |
| sdaOe | output | 1 | Pull SDA low (acknowledge) |
| dutySel | output | 2 | Multiplex mode: 0 static, 1 two-way, 2 three-way, 3 four-way |
| biasSel | output | 1 | Bias selection |
| dispEn | output | 1 | Display enable |
| bankSel | output | 2 | Display bank selection |
| blinkSel | output | 2 | Blink mode |
| ramWe | output | 1 | Display RAM write strobe |
| ramAddr | output | 6 | Display RAM write address |
| ramData | output | 8 | Display RAM write data |

## Verification
The pointer and the subaddress counter are never visible on a port. A wrong value in either first shows up at the next display byte, which then has the wrong `ramAddr`, is written when it should not be, or is missing. A wrong acknowledge decision shows up on `sdaOe` within the same ninth clock phase. A parser stuck in the wrong phase turns command bytes into RAM writes, or the reverse. The bench model predicts every write, so an unexpected or missing `ramWe` pulse is caught in the clock where it happens, or when the queue is checked at the end of the run. Register corruption is caught at the check that follows each transfer.

// File: rtl/lcdRxPkg.sv
package lcdRxPkg;

  // Fixed upper six bits of the slave address; the strap supplies bit 0.
  localparam logic [5:0] ADDR_UPPER = 6'b011100;

  // Strobes issued by the control path, one clock wide.
  typedef struct packed {
    logic       cmdStb;
    logic       dataStb;
    logic [7:0] byteVal;
  } rxStb_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_DATA,
    PH_SKIP
  } rxPhase_t;

endpackage

// File: rtl/lcdRxCtrl.sv
module lcdRxCtrl
  import lcdRxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  logic   sa0Strap,
  input  logic   subMatch,
  output rxStb_t stb,
  output logic   ackOe
);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclQ, sdaQ;
  logic sclS, sdaS;
  rxPhase_t phase;
  logic [3:0] bitCnt;
  logic [7:0] shReg;

  assign sclS = sclSh[SYNC_STAGES-1];
  assign sdaS = sdaSh[SYNC_STAGES-1];

  // Synchronizer chains, one per bus line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclQ  <= 1'b1;
      sdaQ  <= 1'b1;
    end else begin
      sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclQ  <= sclS;
      sdaQ  <= sdaS;
    end
  end

  logic sclRise, sclFall, startDet, stopDet, active;
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign active   = (phase == PH_ADDR) || (phase == PH_CMD) || (phase == PH_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      shReg  <= '0;
      ackOe  <= 1'b0;
      stb    <= '0;
    end else begin
      stb.cmdStb  <= 1'b0;
      stb.dataStb <= 1'b0;
      if (startDet) begin
        phase  <= PH_ADDR;
        bitCnt <= '0;
        ackOe  <= 1'b0;
      end else if (stopDet) begin
        phase  <= PH_IDLE;
        bitCnt <= '0;
        ackOe  <= 1'b0;
      end else if (active) begin
        if (sclRise && bitCnt < 4'd8) begin
          shReg  <= {shReg[6:0], sdaS};
          bitCnt <= bitCnt + 4'd1;
        end else if (sclFall && bitCnt == 4'd8) begin
          bitCnt <= 4'd9;
          unique case (phase)
            PH_ADDR: begin
              if (shReg[7:1] == {ADDR_UPPER, sa0Strap} && !shReg[0]) begin
                ackOe <= 1'b1;
                phase <= PH_CMD;
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_CMD: begin
              ackOe       <= 1'b1;
              stb.cmdStb  <= 1'b1;
              stb.byteVal <= shReg;
              if (!shReg[7]) phase <= PH_DATA;
            end
            PH_DATA: begin
              ackOe       <= subMatch;
              stb.dataStb <= 1'b1;
              stb.byteVal <= shReg;
            end
            default: ;
          endcase
        end else if (sclFall && bitCnt == 4'd9) begin
          ackOe  <= 1'b0;
          bitCnt <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/lcdRxData.sv
module lcdRxData
  import lcdRxPkg::*;
#(
  parameter  int RAM_DEPTH = 40,
  localparam int PTR_W     = $clog2(RAM_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStb_t           stb,
  input  logic [2:0]       subAddr,
  output logic             subMatch,
  output logic [1:0]       dutySel,
  output logic             biasSel,
  output logic             dispEn,
  output logic [1:0]       bankSel,
  output logic [1:0]       blinkSel,
  output logic             ramWe,
  output logic [PTR_W-1:0] ramAddr,
  output logic [7:0]       ramData
);

  localparam logic [PTR_W:0] DEPTH_V  = (PTR_W+1)'(RAM_DEPTH);
  localparam logic [6:0]     LOAD_LIM = 7'(RAM_DEPTH);

  logic [PTR_W-1:0] ptr;
  logic [2:0]       subCnt;
  logic [PTR_W:0]   step, nextSum;
  logic             wrap;
  logic [5:0]       ptrLoad;

  // Positions filled by one display byte for each multiplex mode.
  always_comb begin
    unique case (dutySel)
      2'd0:    step = (PTR_W+1)'(8);
      2'd1:    step = (PTR_W+1)'(4);
      2'd2:    step = (PTR_W+1)'(3);
      default: step = (PTR_W+1)'(2);
    endcase
  end

  assign nextSum  = {1'b0, ptr} + step;
  assign wrap     = nextSum >= DEPTH_V;
  assign ptrLoad  = stb.byteVal[5:0];
  assign subMatch = (subCnt == subAddr);
  assign ramWe    = stb.dataStb & subMatch;
  assign ramAddr  = ptr;
  assign ramData  = stb.byteVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      subCnt   <= '0;
      dutySel  <= '0;
      biasSel  <= 1'b0;
      dispEn   <= 1'b0;
      bankSel  <= '0;
      blinkSel <= '0;
    end else if (stb.cmdStb) begin
      casez (stb.byteVal[6:0])
        7'b0??????: ptr <= ({1'b0, ptrLoad} < LOAD_LIM) ? PTR_W'(ptrLoad) : '0;
        7'b10?????: begin
          dispEn  <= stb.byteVal[3];
          biasSel <= stb.byteVal[2];
          dutySel <= stb.byteVal[1:0];
        end
        7'b1100???: subCnt   <= stb.byteVal[2:0];
        7'b1110???: bankSel  <= stb.byteVal[1:0];
        7'b1111???: blinkSel <= stb.byteVal[1:0];
        default: ;
      endcase
    end else if (stb.dataStb) begin
      if (wrap) begin
        ptr    <= '0;
        subCnt <= subCnt + 3'd1;
      end else begin
        ptr <= nextSum[PTR_W-1:0];
      end
    end
  end

endmodule

// File: rtl/lcdI2cRx.sv
module lcdI2cRx
  import lcdRxPkg::*;
#(
  parameter  int RAM_DEPTH   = 40,
  parameter  int SYNC_STAGES = 2,
  localparam int PTR_W       = $clog2(RAM_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             sa0Strap,
  input  logic [2:0]       subAddr,
  output logic             sdaOe,
  output logic [1:0]       dutySel,
  output logic             biasSel,
  output logic             dispEn,
  output logic [1:0]       bankSel,
  output logic [1:0]       blinkSel,
  output logic             ramWe,
  output logic [PTR_W-1:0] ramAddr,
  output logic [7:0]       ramData
);

  rxStb_t rxStb;
  logic   subMatch;

  lcdRxCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .sa0Strap(sa0Strap),
    .subMatch(subMatch),
    .stb     (rxStb),
    .ackOe   (sdaOe)
  );

  lcdRxData #(.RAM_DEPTH(RAM_DEPTH)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (rxStb),
    .subAddr (subAddr),
    .subMatch(subMatch),
    .dutySel (dutySel),
    .biasSel (biasSel),
    .dispEn  (dispEn),
    .bankSel (bankSel),
    .blinkSel(blinkSel),
    .ramWe   (ramWe),
    .ramAddr (ramAddr),
    .ramData (ramData)
  );

endmodule

// File: rtl/lcdRxChk.sv
module lcdRxChk #(
  parameter  int RAM_DEPTH = 40,
  localparam int PTR_W     = $clog2(RAM_DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaOe,
  input logic             ramWe,
  input logic [PTR_W-1:0] ramAddr,
  input logic             cmdStb,
  input logic [7:0]       regVec
);

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> !ramWe); // R7

  AST_WE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> sdaOe); // R7

  AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (int'(ramAddr) < RAM_DEPTH)); // R9

  AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn); // R10

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmdStb |=> $stable(regVec)); // R4

endmodule

bind lcdI2cRx lcdRxChk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sclIn  (sclIn),
  .sdaOe  (sdaOe),
  .ramWe  (ramWe),
  .ramAddr(ramAddr),
  .cmdStb (rxStb.cmdStb),
  .regVec ({dutySel, biasSel, dispEn, bankSel, blinkSel})
);

// File: tb/lcdI2cRx_bench.sv
module lcdI2cRx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclDrv = 1'b1;
  logic       sdaDrv = 1'b1;
  logic       sa0 = 1'b0;
  logic [2:0] subA = 3'd2;
  logic       sdaLine;
  logic       sdaOe, biasSel, dispEn, ramWe;
  logic [1:0] dutySel, bankSel, blinkSel;
  logic [5:0] ramAddr;
  logic [7:0] ramData;

  assign sdaLine = sdaDrv & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcdI2cRx u_lcdI2cRx (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sa0Strap(sa0), .subAddr(subA), .sdaOe(sdaOe),
    .dutySel(dutySel), .biasSel(biasSel), .dispEn(dispEn),
    .bankSel(bankSel), .blinkSel(blinkSel),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData)
  );

  int checks = 0, fails = 0, monChecks = 0, monFails = 0;

  // Reference model state.
  int mPtr = 0, mSub = 0, mDuty = 0, mBias = 0, mEn = 0, mBank = 0, mBlink = 0;
  logic [13:0] expQ[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun(input int extraFail);
    int tot, bad;
    tot = checks + monChecks + extraFail;
    bad = fails + monFails + extraFail;
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  endtask

  function automatic int stepOf(input int d);
    case (d)
      0: return 8;
      1: return 4;
      2: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic mCmd(input logic [7:0] b);
    if (!b[6]) mPtr = (b[5:0] < 40) ? int'(b[5:0]) : 0;           // R5
    else if (b[6:5] == 2'b10) begin                                 // R4
      mEn = b[3]; mBias = b[2]; mDuty = b[1:0];
    end else begin                                                  // R6
      case (b[4:3])
        2'b00: mSub = b[2:0];
        2'b10: mBank = b[1:0];
        2'b11: mBlink = b[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic mData(input logic [7:0] b, output bit ack);
    int st;
    ack = (mSub == int'(subA));
    if (ack) expQ.push_back({6'(mPtr), b});
    st = stepOf(mDuty);
    if (mPtr + st >= 40) begin mPtr = 0; mSub = (mSub + 1) % 8; end  // R9
    else mPtr = mPtr + st;                                            // R8
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; tick(HALF);
    sclDrv = 1'b1; tick(HALF);
    sdaDrv = 1'b0; tick(HALF);
    sclDrv = 1'b0; tick(HALF);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick(HALF);
    sclDrv = 1'b1; tick(HALF);
    sdaDrv = 1'b1; tick(HALF);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; tick(HALF);
      sclDrv = 1'b1; tick(HALF);
      sclDrv = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    sendBits(b, 8);
    sdaDrv = 1'b1; tick(HALF);
    sclDrv = 1'b1; tick(HALF/2);
    @(negedge clk);
    chk(sdaOe == expAck, req, "ack in ninth high", sdaOe, expAck);
    tick(HALF/2);
    sclDrv = 1'b0; tick(6);
    chk(sdaOe == 1'b0, "R10", "ack released after ninth fall", sdaOe, 0);
  endtask

  task automatic cmdByte(input logic [7:0] b);
    mCmd(b);
    sendByte(b, 1'b1, "R3");
  endtask

  task automatic dataByte(input logic [7:0] b);
    bit a;
    mData(b, a);
    sendByte(b, a, "R7");
  endtask

  task automatic checkRegs(input string req);
    @(negedge clk);
    chk(int'(dutySel) == mDuty, req, "dutySel", dutySel, mDuty);
    chk(int'(biasSel) == mBias, req, "biasSel", biasSel, mBias);
    chk(int'(dispEn) == mEn, req, "dispEn", dispEn, mEn);
    chk(int'(bankSel) == mBank, "R6", "bankSel", bankSel, mBank);
    chk(int'(blinkSel) == mBlink, "R6", "blinkSel", blinkSel, mBlink);
  endtask

  // Per-clock write monitor against the model's queue (R7).
  always @(negedge clk) begin
    if (rstN && ramWe) begin
      monChecks++;
      if (expQ.size() == 0) begin
        monFails++;
        $display("FAIL R7 unexpected write: actual addr %0d data %0d expected none",
                 ramAddr, ramData);
      end else begin
        logic [13:0] e;
        e = expQ.pop_front();
        if ({ramAddr, ramData} != e) begin
          monFails++;
          $display("FAIL R7 write: actual addr %0d data %0d expected addr %0d data %0d",
                   ramAddr, ramData, e[13:8], e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual hung expected finished");
    finishRun(1);
  end

  initial begin
    bit dummy;
    tick(5);
    rstN = 1'b1;
    tick(5);
    // R1 reset state
    @(negedge clk);
    chk(sdaOe == 1'b0, "R1", "sdaOe after reset", sdaOe, 0);
    checkRegs("R1");

    // R2 R3 R4 R6 R7 R8: full command chain then data with duty 1
    busStart();
    sendByte(8'h70, 1'b1, "R2");
    cmdByte(8'hCD);   // mode: enable, bias, duty 1
    cmdByte(8'hE2);   // subaddress counter 2
    cmdByte(8'hF1);   // bank 1
    cmdByte(8'hFA);   // blink 2
    cmdByte(8'hE8);   // reserved 1101: no effect (R6)
    cmdByte(8'h05);   // pointer 5, last command
    dataByte(8'hA5);
    dataByte(8'h3C);
    dataByte(8'h81);  // R3: bit 7 set but still data
    busStop();
    checkRegs("R4");

    // R8 R9: duty 3, skipped device then wrap into this one
    busStart();
    sendByte(8'h70, 1'b1, "R2");
    cmdByte(8'hCB);
    cmdByte(8'hE1);   // counter 1, not ours: command still acked (R3)
    cmdByte(8'h26);   // pointer 38
    dataByte(8'h11);  // no ack, wraps to 0, counter 2 (R9)
    dataByte(8'h22);  // written at 0
    dataByte(8'h33);  // written at 2
    busStop();
    checkRegs("R8");

    // R8: duty 2 (step 3) across the end
    busStart();
    sendByte(8'h70, 1'b1, "R2");
    cmdByte(8'hCA);
    cmdByte(8'hE2);
    cmdByte(8'h24);   // pointer 36
    dataByte(8'h44);  // at 36, then 39
    dataByte(8'h55);  // at 39, then wrap to counter 3
    dataByte(8'h66);  // not ours
    busStop();

    // R9: static duty, step 8, wrap from 32
    busStart();
    sendByte(8'h70, 1'b1, "R2");
    cmdByte(8'hC8);
    cmdByte(8'hE2);
    cmdByte(8'h20);
    dataByte(8'h77);
    dataByte(8'h88);  // counter now 3: ignored
    busStop();
    checkRegs("R4");

    // R2: wrong strap bit, whole transfer ignored
    busStart();
    sendByte(8'h72, 1'b0, "R2");
    sendByte(8'hC5, 1'b0, "R2");
    sendByte(8'h00, 1'b0, "R2");
    sendByte(8'h99, 1'b0, "R2");
    busStop();
    checkRegs("R2");
    // R2: read bit set is not accepted
    busStart();
    sendByte(8'h71, 1'b0, "R2");
    sendByte(8'h4A, 1'b0, "R2");
    busStop();
    checkRegs("R2");
    // R2: other strap level now matches
    sa0 = 1'b1;
    busStart();
    sendByte(8'h72, 1'b1, "R2");
    cmdByte(8'hC7);
    busStop();
    checkRegs("R2");

    // R5: pointer load above 39 gives 0
    busStart();
    sendByte(8'h72, 1'b1, "R2");
    cmdByte(8'hE2);
    cmdByte(8'h30);
    dataByte(8'hBE);
    busStop();

    // R11: START in mid byte restarts parsing
    busStart();
    sendByte(8'h72, 1'b1, "R2");
    cmdByte(8'h9E);   // continuing command chain
    sendBits(8'hFF, 4);
    busStart();
    sendByte(8'h72, 1'b1, "R11");
    cmdByte(8'h0A);   // pointer 10, last
    dataByte(8'h5A);
    busStop();
    // R11: bytes after STOP without START are ignored
    sendByte(8'h72, 1'b0, "R11");
    sendByte(8'h00, 1'b0, "R11");
    sendByte(8'hEE, 1'b0, "R11");
    checkRegs("R11");
    dummy = 1'b0;

    tick(10);
    chk(expQ.size() == 0, "R7", "pending expected writes", expQ.size(), 0);
    finishRun(0);
  end

endmodule